// File: doc/BRIEF.md
# Flag-Setting ALU with Condition Evaluator

This block is the integer execute stage of a processor datapath. It takes a first operand, a second operand that has already been through the barrel shifter, and that shifter's carry-out. From these it produces a 32-bit result and the next N, Z, C, V flags for one of sixteen data-processing opcodes. A condition evaluator sits beside the ALU. It checks the 4-bit condition field of the instruction against the flags that are currently stored, and it gates both the result write and the flag update.

The whole block is combinational. The caller holds the flag register. It feeds the current flags in on `flags_in` and writes `flags_out` back every cycle. `flags_out` equals `flags_in` whenever no update is due, so the caller can write it back without checking. Subtraction treats carry as "no borrow": an incoming C of 0 means a borrow is pending. The four compare-class opcodes only set flags and never raise the write enable.

Top module: `dp_exec_unit`

## Requirements
- R1: Opcode ADD (4) gives A+B and opcode ADC (5) gives A+B+C. When flags update, C is the carry out of bit 31. Flags are packed {N,Z,C,V} in bits 3..0 of `flags_in` and `flags_out`.
- R2: Opcode SUB (2) gives A−B and opcode SBC (6) gives A−B−(1−C). When flags update, C is 1 when no borrow occurs.
- R3: Opcode RSB (3) gives B−A and opcode RSC (7) gives B−A−(1−C), with the same carry rule as R2.
- R4: For every add or subtract form, V is set on signed overflow of that operation when flags update.
- R5: The logical opcodes give these results: AND (0) gives A&B, EOR (1) gives A^B, ORR (12) gives A|B, BIC (14) gives A&~B, MOV (13) gives B, and MVN (15) gives ~B.
- R6: When a logical or test opcode updates flags, N is bit 31 of the result and Z is set when the result is zero. C takes `shift_carry` and V keeps its input value.
- R7: Opcodes TST (8, A&B), TEQ (9, A^B), CMP (10, A−B) and CMN (11, A+B) never assert `result_we`. They update flags whenever their condition passes, whatever the value of `set_flags`.
- R8: A non-compare opcode whose condition passes asserts `result_we`. It updates flags only when `set_flags` is 1; otherwise `flags_out` equals `flags_in`.
- R9: The single-flag conditions pass as follows: EQ=0 when Z, NE=1 when !Z, CS=2 when C, CC=3 when !C, MI=4 when N, PL=5 when !N, VS=6 when V, VC=7 when !V.
- R10: The compound conditions pass as follows: HI=8 when C&!Z, LS=9 when !C|Z, GE=10 when N==V, LT=11 when N!=V, GT=12 when !Z&(N==V), LE=13 when Z|(N!=V).
- R11: Condition AL=14 always passes and NV=15 never passes. When the condition fails, `result_we` is 0 and `flags_out` equals `flags_in`.
- R12: `result` always carries the value the opcode computes, even when `result_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry out of the shifter |
| flags_in | input | 4 | Stored flags {N,Z,C,V} |
| opcode | input | 4 | Data-processing opcode |
| set_flags | input | 1 | Request a flag update |
| cond_code | input | 4 | Condition field |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| result_we | output | 1 | Write enable for the result |
| cond_pass | output | 1 | Condition evaluated true |

## Verification
Every output is a pure function of the inputs present in the same cycle, so each result is due with zero cycles of latency. The bench drives new inputs on the falling clock edge and samples all four outputs 1 ns later. Sampling then is well before the next rising edge, so no check depends on the order in which processes run at an edge. The rising edge is used only to pace the run and the watchdog.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dp_op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } dp_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } dp_flags_t;

  function automatic logic op_is_compare(dp_op_e op);
    return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
  endfunction

  function automatic logic op_is_arith(dp_op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC,
                       OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/dp_cond_eval.sv
module dp_cond_eval
  import dp_alu_pkg::*;
(
  input  dp_flags_t flg,
  input  dp_cond_e  cc,
  output logic      pass
);

  logic sgn_eq;
  assign sgn_eq = (flg.n == flg.v);

  always_comb begin
    unique case (cc)
      CC_EQ:   pass = flg.z;
      CC_NE:   pass = !flg.z;
      CC_CS:   pass = flg.c;
      CC_CC:   pass = !flg.c;
      CC_MI:   pass = flg.n;
      CC_PL:   pass = !flg.n;
      CC_VS:   pass = flg.v;
      CC_VC:   pass = !flg.v;
      CC_HI:   pass = flg.c && !flg.z;
      CC_LS:   pass = !flg.c || flg.z;
      CC_GE:   pass = sgn_eq;
      CC_LT:   pass = !sgn_eq;
      CC_GT:   pass = !flg.z && sgn_eq;
      CC_LE:   pass = flg.z || !sgn_eq;
      CC_AL:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/dp_arith.sv
module dp_arith
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  dp_op_e       op,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         ovf
);

  localparam int MSB = W - 1;

  logic [W-1:0] x_opnd;
  logic [W-1:0] y_opnd;
  logic         cin;
  logic [W:0]   wide;

  // One shared adder: swap for reverse forms, invert for subtract forms.
  always_comb begin
    x_opnd = a;
    y_opnd = b;
    cin    = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: cin = 1'b0;
      OP_ADC:         cin = c_in;
      OP_SUB, OP_CMP: begin y_opnd = ~b; cin = 1'b1; end
      OP_SBC:         begin y_opnd = ~b; cin = c_in; end
      OP_RSB:         begin x_opnd = b; y_opnd = ~a; cin = 1'b1; end
      OP_RSC:         begin x_opnd = b; y_opnd = ~a; cin = c_in; end
      default:        cin = 1'b0;
    endcase
  end

  assign wide  = {1'b0, x_opnd} + {1'b0, y_opnd} + {{W{1'b0}}, cin};
  assign sum   = wide[W-1:0];
  assign c_out = wide[W];
  assign ovf   = (x_opnd[MSB] == y_opnd[MSB]) && (sum[MSB] != x_opnd[MSB]);

endmodule

// File: rtl/dp_logic.sv
module dp_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  dp_op_e       op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_BIC:         y = a & ~b;
      OP_MOV:         y = b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end

endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         shift_carry,
  input  logic [3:0]   flags_in,
  input  logic [3:0]   opcode,
  input  logic         set_flags,
  input  logic [3:0]   cond_code,
  output logic [W-1:0] result,
  output logic [3:0]   flags_out,
  output logic         result_we,
  output logic         cond_pass
);

  localparam int MSB = W - 1;

  dp_op_e    op;
  dp_cond_e  cc;
  dp_flags_t cur;
  dp_flags_t nxt;
  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic         arith_c;
  logic         arith_v;
  logic         is_cmp;
  logic         is_arith;
  logic         pass;
  logic         upd;

  assign op  = dp_op_e'(opcode);
  assign cc  = dp_cond_e'(cond_code);
  assign cur = dp_flags_t'(flags_in);

  dp_cond_eval u_cond (
    .flg  (cur),
    .cc   (cc),
    .pass (pass)
  );

  dp_arith #(.W(W)) u_arith (
    .a     (opnd_a),
    .b     (opnd_b),
    .c_in  (cur.c),
    .op    (op),
    .sum   (arith_y),
    .c_out (arith_c),
    .ovf   (arith_v)
  );

  dp_logic #(.W(W)) u_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .op (op),
    .y  (logic_y)
  );

  assign is_cmp   = op_is_compare(op);
  assign is_arith = op_is_arith(op);
  assign upd      = pass && (set_flags || is_cmp);

  always_comb begin
    result = is_arith ? arith_y : logic_y;
    nxt    = cur;
    if (upd) begin
      nxt.n = result[MSB];
      nxt.z = (result == '0);
      nxt.c = is_arith ? arith_c : shift_carry;
      nxt.v = is_arith ? arith_v : cur.v;
    end
  end

  assign flags_out = nxt;
  assign result_we = pass && !is_cmp;
  assign cond_pass = pass;

endmodule

// File: rtl/dp_exec_checker.sv
module dp_exec_checker #(
  parameter int W = 32
) (
  input logic [W-1:0] result,
  input logic [3:0]   flags_in,
  input logic [3:0]   opcode,
  input logic         set_flags,
  input logic [3:0]   cond_code,
  input logic [3:0]   flags_out,
  input logic         result_we,
  input logic         cond_pass
);

  logic cmp_class;
  logic logic_class;
  assign cmp_class   = (opcode[3:2] == 2'b10);
  assign logic_class = (opcode inside {4'd0, 4'd1, 4'd8, 4'd9,
                                       4'd12, 4'd13, 4'd14, 4'd15});

  always_comb begin
    if (cmp_class)
      p_cmp_no_write_r7: assert (!result_we)
        else $error("compare opcode raised the write enable");
    if (!cond_pass)
      p_fail_hold_r11: assert (!result_we && flags_out == flags_in)
        else $error("failed condition changed state");
    if (cond_code == 4'd14)
      p_al_pass_r11: assert (cond_pass) else $error("AL did not pass");
    if (cond_code == 4'd15)
      p_nv_block_r11: assert (!cond_pass) else $error("NV passed");
    if (cond_pass && !set_flags && !cmp_class)
      p_nos_hold_r8: assert (flags_out == flags_in && result_we)
        else $error("flags moved without a set-flags request");
    if (cond_pass && (set_flags || cmp_class))
      p_nz_track_r6: assert (flags_out[3] == result[W-1] &&
                             flags_out[2] == (result == '0))
        else $error("N or Z does not match the result");
    if (cond_pass && (set_flags || cmp_class) && logic_class)
      p_logic_v_keep_r6: assert (flags_out[0] == flags_in[0])
        else $error("logical opcode altered V");
  end

endmodule

bind dp_exec_unit dp_exec_checker #(.W(W)) u_dp_exec_checker (
  .result    (result),
  .flags_in  (flags_in),
  .opcode    (opcode),
  .set_flags (set_flags),
  .cond_code (cond_code),
  .flags_out (flags_out),
  .result_we (result_we),
  .cond_pass (cond_pass)
);

// File: tb/test_dp_exec_unit.sv
`timescale 1ns/1ps
module test_dp_exec_unit;

  localparam int NV = 29;

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic        s;
    logic [3:0]  cc;
    logic [3:0]  fin;
    logic        shc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [3:0]  fout;
    logic        we;
    logic        pass;
  } vec_t;

  // flags are {N,Z,C,V}; cc 14 = AL
  localparam vec_t VECS [NV] = '{
    '{8'd1, 4'd4, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h1, 32'h2, 32'h3, 4'b0000, 1'b1, 1'b1},                 // R1
    '{8'd1, 4'd4, 1'b1, 4'd14, 4'b0000, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h0, 4'b0110, 1'b1, 1'b1},          // R1
    '{8'd1, 4'd5, 1'b1, 4'd14, 4'b0010, 1'b0, 32'h5, 32'h7, 32'hD, 4'b0000, 1'b1, 1'b1},                 // R1
    '{8'd1, 4'd5, 1'b1, 4'd14, 4'b0010, 1'b0, 32'hFFFFFFFF, 32'h0, 32'h0, 4'b0110, 1'b1, 1'b1},          // R1
    '{8'd2, 4'd2, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h5, 32'h3, 32'h2, 4'b0010, 1'b1, 1'b1},                 // R2
    '{8'd2, 4'd2, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h3, 32'h5, 32'hFFFFFFFE, 4'b1000, 1'b1, 1'b1},          // R2
    '{8'd2, 4'd6, 1'b1, 4'd14, 4'b0000, 1'b0, 32'hA, 32'h3, 32'h6, 4'b0010, 1'b1, 1'b1},                 // R2
    '{8'd2, 4'd6, 1'b1, 4'd14, 4'b0010, 1'b0, 32'h3, 32'h3, 32'h0, 4'b0110, 1'b1, 1'b1},                 // R2
    '{8'd3, 4'd3, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h3, 32'hA, 32'h7, 4'b0010, 1'b1, 1'b1},                 // R3
    '{8'd3, 4'd7, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h3, 32'hA, 32'h6, 4'b0010, 1'b1, 1'b1},                 // R3
    '{8'd3, 4'd3, 1'b1, 4'd14, 4'b0000, 1'b0, 32'hA, 32'h3, 32'hFFFFFFF9, 4'b1000, 1'b1, 1'b1},          // R3
    '{8'd4, 4'd4, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h7FFFFFFF, 32'h1, 32'h80000000, 4'b1001, 1'b1, 1'b1},   // R4
    '{8'd4, 4'd2, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h80000000, 32'h1, 32'h7FFFFFFF, 4'b0011, 1'b1, 1'b1},   // R4
    '{8'd5, 4'd0, 1'b0, 4'd14, 4'b0101, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'b0101, 1'b1, 1'b1}, // R5
    '{8'd5, 4'd1, 1'b0, 4'd14, 4'b0000, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 4'b0000, 1'b1, 1'b1}, // R5
    '{8'd5, 4'd12, 1'b0, 4'd14, 4'b0000, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 4'b0000, 1'b1, 1'b1}, // R5
    '{8'd5, 4'd14, 1'b0, 4'd14, 4'b0000, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h00F000F0, 4'b0000, 1'b1, 1'b1}, // R5
    '{8'd5, 4'd13, 1'b0, 4'd14, 4'b0000, 1'b0, 32'hAAAA0000, 32'h12345678, 32'h12345678, 4'b0000, 1'b1, 1'b1}, // R5
    '{8'd5, 4'd15, 1'b0, 4'd14, 4'b0000, 1'b0, 32'h1, 32'h0, 32'hFFFFFFFF, 4'b0000, 1'b1, 1'b1},         // R5
    '{8'd6, 4'd13, 1'b1, 4'd14, 4'b0001, 1'b1, 32'h0, 32'h0, 32'h0, 4'b0111, 1'b1, 1'b1},                // R6
    '{8'd6, 4'd0, 1'b1, 4'd14, 4'b0010, 1'b0, 32'h80000000, 32'h80000001, 32'h80000000, 4'b1000, 1'b1, 1'b1}, // R6
    '{8'd7, 4'd10, 1'b0, 4'd14, 4'b0000, 1'b0, 32'h5, 32'h5, 32'h0, 4'b0110, 1'b0, 1'b1},               // R7
    '{8'd7, 4'd11, 1'b0, 4'd14, 4'b0000, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h0, 4'b0110, 1'b0, 1'b1},        // R7
    '{8'd7, 4'd8, 1'b0, 4'd14, 4'b0011, 1'b0, 32'h1, 32'h2, 32'h0, 4'b0101, 1'b0, 1'b1},                // R7
    '{8'd7, 4'd9, 1'b0, 4'd14, 4'b0000, 1'b1, 32'h5, 32'h5, 32'h0, 4'b0110, 1'b0, 1'b1},                // R7
    '{8'd8, 4'd4, 1'b0, 4'd14, 4'b1010, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h0, 4'b1010, 1'b1, 1'b1},         // R8
    '{8'd11, 4'd4, 1'b1, 4'd0, 4'b0000, 1'b0, 32'h1, 32'h2, 32'h3, 4'b0000, 1'b0, 1'b0},                // R11, EQ fails
    '{8'd12, 4'd10, 1'b1, 4'd1, 4'b0100, 1'b0, 32'h5, 32'h3, 32'h2, 4'b0100, 1'b0, 1'b0},               // R12, NE fails
    '{8'd11, 4'd13, 1'b1, 4'd15, 4'b0000, 1'b0, 32'h0, 32'h55, 32'h55, 4'b0000, 1'b0, 1'b0}             // R11, NV
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] opnd_a, opnd_b, result;
  logic        shift_carry, set_flags, result_we, cond_pass;
  logic [3:0]  flags_in, opcode, cond_code, flags_out;
  int          n_tests, n_fail, cyc;

  dp_exec_unit i_dp_exec_unit (
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .shift_carry (shift_carry),
    .flags_in    (flags_in),
    .opcode      (opcode),
    .set_flags   (set_flags),
    .cond_code   (cond_code),
    .result      (result),
    .flags_out   (flags_out),
    .result_we   (result_we),
    .cond_pass   (cond_pass)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual %0d cycles, expected under 100000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  function automatic logic ref_pass(logic [3:0] cc, logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] er,
                       input logic [3:0] ef, input logic ew, input logic ep);
    n_tests++;
    if (result !== er || flags_out !== ef || result_we !== ew || cond_pass !== ep) begin
      n_fail++;
      $display("FAIL %s: actual res=%h flags=%b we=%b pass=%b, expected res=%h flags=%b we=%b pass=%b",
               tag, result, flags_out, result_we, cond_pass, er, ef, ew, ep);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic s, input logic [3:0] cc,
                       input logic [3:0] fin, input logic shc,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opcode = op; set_flags = s; cond_code = cc; flags_in = fin;
    shift_carry = shc; opnd_a = a; opnd_b = b;
    #1;
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    rst_n = 1'b0;
    opnd_a = '0; opnd_b = '0; shift_carry = 1'b0; flags_in = '0;
    opcode = '0; set_flags = 1'b0; cond_code = 4'd15;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // idle state under reset: NV blocks everything (R11)
    check("R11 idle", 32'h0, 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].s, VECS[i].cc, VECS[i].fin, VECS[i].shc, VECS[i].a, VECS[i].b);
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            VECS[i].res, VECS[i].fout, VECS[i].we, VECS[i].pass);
    end

    // every condition against every flag pattern, MOV without set-flags
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic ep;
        string tag;
        ep  = ref_pass(4'(c), 4'(f));
        tag = (c < 8) ? "R9" : ((c < 14) ? "R10" : "R11");
        drive(4'd13, 1'b0, 4'(c), 4'(f), 1'b1, 32'h0, 32'h55);
        check($sformatf("%s cc=%0d f=%b", tag, c, 4'(f)), 32'h55, 4'(f), ep, ep);
      end
    end

    // corner: RSC with borrow pending and equal operands wraps to all-ones (R3)
    drive(4'd7, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h9, 32'h9);
    check("R3 rsc wrap", 32'hFFFFFFFF, 4'b1000, 1'b1, 1'b1);
    // corner: SUB of most negative minus positive sets V, CMP does same without write (R4, R7)
    drive(4'd10, 1'b0, 4'd14, 4'b0000, 1'b0, 32'h80000000, 32'h1);
    check("R4 cmp ovf", 32'h7FFFFFFF, 4'b0011, 1'b0, 1'b1);
    // corner: ADD negative overflow 80000000+80000000 (R4)
    drive(4'd4, 1'b1, 4'd14, 4'b0000, 1'b0, 32'h80000000, 32'h80000000);
    check("R4 add neg ovf", 32'h0, 4'b0111, 1'b1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule